// File: doc/BRIEF.md
# Relocatable On-Chip Memory Decoder

This block decodes a 16-bit bus address into one of four on-chip resources: an internal register window, a RAM window, a boot ROM and an EEPROM. The register and RAM windows can be moved. Each one is placed by a 4-bit page number that becomes the top nibble of its base address, so either window can start at the beginning of any 4-Kbyte page. The boot ROM and EEPROM windows are fixed at elaboration time.

Windows may overlap. A fixed ranking decides which resource answers. The register window wins over everything else, then RAM, then boot ROM, then EEPROM. If the register and RAM windows are placed on the same page, the registers cover the bottom 96 bytes of RAM.

The block is purely combinational. For the winning resource it drives that resource's select and the local offset of the address inside it. When no resource claims the address it raises a miss flag, so that an external bus cycle can be started. The two page numbers come from a configuration register outside this block.

Top module: `mem_decoder`

## Requirements
- R1: The register window covers page base `reg_pos_i`×0x1000 up to base+0x5F (96 bytes). Any address inside it asserts `sel_reg_o`, and `sel_reg_o` is never asserted outside it.
- R2: The RAM window covers page base `ram_pos_i`×0x1000 up to base+0x3FF (1 Kbyte). An address inside it and outside the register window asserts `sel_ram_o`, and `sel_ram_o` is never asserted outside it.
- R3: When both windows share a page, addresses base+0x00 to base+0x5F select registers and not RAM, and base+0x60 upward selects RAM.
- R4: The boot ROM window spans ROM_BASE to ROM_BASE+ROM_SIZE−1 (default 0xB000–0xB1FF). It is selected only while `rom_en_i` is 1 and neither the register window nor the RAM window claims the address.
- R5: The EEPROM window spans EEP_BASE to EEP_BASE+EEP_SIZE−1 (default 0xB100–0xB4FF). It is selected only when no higher-ranked resource claims the address.
- R6: The four select outputs are one-hot or all zero for every input combination.
- R7: `miss_o` is 1 exactly when all four selects are 0.
- R8: Each offset output equals the address minus the base of its window while that window is selected, and is 0 otherwise. The widths are 7 bits for registers, 10 bits for RAM, and log2 of the window size for ROM and EEPROM.
- R9: With `rom_en_i` at 0, addresses in the ROM window go to the EEPROM where it overlaps the ROM window, and raise a miss where it does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 16 | Bus address to decode |
| ram_pos_i | input | 4 | Page number of the RAM window |
| reg_pos_i | input | 4 | Page number of the register window |
| rom_en_i | input | 1 | Boot ROM visible when 1 |
| sel_reg_o | output | 1 | Register window selected |
| sel_ram_o | output | 1 | RAM selected |
| sel_rom_o | output | 1 | Boot ROM selected |
| sel_eep_o | output | 1 | EEPROM selected |
| miss_o | output | 1 | No on-chip resource claims the address |
| reg_off_o | output | 7 | Offset inside the register window |
| ram_off_o | output | 10 | Offset inside RAM |
| rom_off_o | output | 9 | Offset inside boot ROM |
| eep_off_o | output | 10 | Offset inside EEPROM |

## Verification
The assertions check the decoder's outputs against its inputs in the same evaluation. They assume that every input holds a known 0/1 value, and that the RAM window size and the register span both fit inside one page. The bench drives only two-state values and uses the default window sizes. The random stimulus often places the address on the page of the RAM window, the register window or the fixed windows, so that every overlap is exercised, including overlaps with the ROM gated off.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;
  typedef enum logic [1:0] {
    RES_REG = 2'd0,
    RES_RAM = 2'd1,
    RES_ROM = 2'd2,
    RES_EEP = 2'd3
  } res_e;
  localparam int unsigned NUM_RES = 4;
endpackage

// File: rtl/mem_dec_window.sv
// Range match of one window; offset is address minus base when hit.
module mem_dec_window #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE   = 1024,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              en_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] base_x;
  logic [ADDR_W:0] lim_x;

  assign addr_x = {1'b0, addr_i};
  assign base_x = {1'b0, base_i};
  // one extra bit so a window ending at the top of the map does not wrap
  assign lim_x  = base_x + (ADDR_W+1)'(SIZE);
  assign hit_o  = en_i && (addr_x >= base_x) && (addr_x < lim_x);
  assign off_o  = OFF_W'(addr_i - base_i);
endmodule

// File: rtl/mem_dec_prio.sv
// Fixed priority: lowest index wins.
module mem_dec_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | req_i[i-1];
  end
  assign gnt_o = req_i & ~blocked;
endmodule

// File: rtl/mem_decoder.sv
module mem_decoder #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned REG_SPAN = 96,
  parameter int unsigned REG_AW   = 7,
  parameter int unsigned RAM_SIZE = 1024,
  parameter logic [15:0] ROM_BASE = 16'hB000,
  parameter int unsigned ROM_SIZE = 512,
  parameter logic [15:0] EEP_BASE = 16'hB100,
  parameter int unsigned EEP_SIZE = 1024,
  localparam int unsigned RAM_OFF_W = $clog2(RAM_SIZE),
  localparam int unsigned ROM_OFF_W = $clog2(ROM_SIZE),
  localparam int unsigned EEP_OFF_W = $clog2(EEP_SIZE)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PAGE_W-1:0]    ram_pos_i,
  input  logic [PAGE_W-1:0]    reg_pos_i,
  input  logic                 rom_en_i,
  output logic                 sel_reg_o,
  output logic                 sel_ram_o,
  output logic                 sel_rom_o,
  output logic                 sel_eep_o,
  output logic                 miss_o,
  output logic [REG_AW-1:0]    reg_off_o,
  output logic [RAM_OFF_W-1:0] ram_off_o,
  output logic [ROM_OFF_W-1:0] rom_off_o,
  output logic [EEP_OFF_W-1:0] eep_off_o
);
  import mem_dec_pkg::*;

  localparam int unsigned LOW_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0]    reg_base, ram_base;
  logic [NUM_RES-1:0]   hit, gnt;
  logic [REG_AW-1:0]    reg_off;
  logic [RAM_OFF_W-1:0] ram_off;
  logic [ROM_OFF_W-1:0] rom_off;
  logic [EEP_OFF_W-1:0] eep_off;

  assign reg_base = {reg_pos_i, {LOW_W{1'b0}}};
  assign ram_base = {ram_pos_i, {LOW_W{1'b0}}};

  mem_dec_window #(.ADDR_W(ADDR_W), .SIZE(REG_SPAN), .OFF_W(REG_AW)) u_win_reg (
    .addr_i(addr_i), .base_i(reg_base), .en_i(1'b1),
    .hit_o(hit[RES_REG]), .off_o(reg_off)
  );
  mem_dec_window #(.ADDR_W(ADDR_W), .SIZE(RAM_SIZE), .OFF_W(RAM_OFF_W)) u_win_ram (
    .addr_i(addr_i), .base_i(ram_base), .en_i(1'b1),
    .hit_o(hit[RES_RAM]), .off_o(ram_off)
  );
  mem_dec_window #(.ADDR_W(ADDR_W), .SIZE(ROM_SIZE), .OFF_W(ROM_OFF_W)) u_win_rom (
    .addr_i(addr_i), .base_i(ADDR_W'(ROM_BASE)), .en_i(rom_en_i),
    .hit_o(hit[RES_ROM]), .off_o(rom_off)
  );
  mem_dec_window #(.ADDR_W(ADDR_W), .SIZE(EEP_SIZE), .OFF_W(EEP_OFF_W)) u_win_eep (
    .addr_i(addr_i), .base_i(ADDR_W'(EEP_BASE)), .en_i(1'b1),
    .hit_o(hit[RES_EEP]), .off_o(eep_off)
  );

  mem_dec_prio #(.N(NUM_RES)) u_prio (.req_i(hit), .gnt_o(gnt));

  assign sel_reg_o = gnt[RES_REG];
  assign sel_ram_o = gnt[RES_RAM];
  assign sel_rom_o = gnt[RES_ROM];
  assign sel_eep_o = gnt[RES_EEP];
  assign miss_o    = ~|hit;

  // offsets held at zero unless their window wins
  assign reg_off_o = gnt[RES_REG] ? reg_off : '0;
  assign ram_off_o = gnt[RES_RAM] ? ram_off : '0;
  assign rom_off_o = gnt[RES_ROM] ? rom_off : '0;
  assign eep_off_o = gnt[RES_EEP] ? eep_off : '0;
endmodule

// File: rtl/mem_decoder_chk.sv
module mem_decoder_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned REG_SPAN  = 96,
  parameter int unsigned REG_AW    = 7,
  parameter int unsigned RAM_SIZE  = 1024,
  parameter int unsigned RAM_OFF_W = 10,
  parameter int unsigned ROM_OFF_W = 9,
  parameter int unsigned EEP_OFF_W = 10
) (
  input logic [ADDR_W-1:0]    addr_i,
  input logic [PAGE_W-1:0]    ram_pos_i,
  input logic [PAGE_W-1:0]    reg_pos_i,
  input logic                 rom_en_i,
  input logic                 sel_reg_o,
  input logic                 sel_ram_o,
  input logic                 sel_rom_o,
  input logic                 sel_eep_o,
  input logic                 miss_o,
  input logic [REG_AW-1:0]    reg_off_o,
  input logic [RAM_OFF_W-1:0] ram_off_o,
  input logic [ROM_OFF_W-1:0] rom_off_o,
  input logic [EEP_OFF_W-1:0] eep_off_o
);
  localparam int unsigned LOW_W = ADDR_W - PAGE_W;

  logic [LOW_W-1:0] low;
  logic in_reg, in_ram;

  assign low    = addr_i[LOW_W-1:0];
  assign in_reg = (addr_i[ADDR_W-1:LOW_W] == reg_pos_i) && (low < LOW_W'(REG_SPAN));
  assign in_ram = (addr_i[ADDR_W-1:LOW_W] == ram_pos_i) && (low < LOW_W'(RAM_SIZE));

  always_comb begin
    p_reg_window_r1: assert (sel_reg_o == in_reg);
    p_ram_window_r2: assert (!sel_ram_o || in_ram);
    p_reg_over_ram_r3: assert (!(in_reg && in_ram) || (sel_reg_o && !sel_ram_o));
    p_rom_rank_r4: assert (!sel_rom_o || (rom_en_i && !in_reg && !in_ram));
    p_eep_rank_r5: assert (!sel_eep_o || (!in_reg && !in_ram));
    p_onehot_sel_r6: assert ($onehot0({sel_reg_o, sel_ram_o, sel_rom_o, sel_eep_o}));
    p_miss_r7: assert (miss_o == !(sel_reg_o || sel_ram_o || sel_rom_o || sel_eep_o));
    p_reg_off_r8: assert (sel_reg_o ? (reg_off_o == REG_AW'(low)) : (reg_off_o == '0));
    p_ram_off_r8: assert (sel_ram_o ? (ram_off_o == RAM_OFF_W'(low)) : (ram_off_o == '0));
    p_rom_off_r8: assert (sel_rom_o || rom_off_o == '0);
    p_eep_off_r8: assert (sel_eep_o || eep_off_o == '0);
    p_rom_gate_r9: assert (rom_en_i || !sel_rom_o);
  end
endmodule

bind mem_decoder mem_decoder_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_SPAN(REG_SPAN), .REG_AW(REG_AW),
  .RAM_SIZE(RAM_SIZE), .RAM_OFF_W(RAM_OFF_W), .ROM_OFF_W(ROM_OFF_W), .EEP_OFF_W(EEP_OFF_W)
) u_chk (
  .addr_i(addr_i), .ram_pos_i(ram_pos_i), .reg_pos_i(reg_pos_i), .rom_en_i(rom_en_i),
  .sel_reg_o(sel_reg_o), .sel_ram_o(sel_ram_o), .sel_rom_o(sel_rom_o), .sel_eep_o(sel_eep_o),
  .miss_o(miss_o), .reg_off_o(reg_off_o), .ram_off_o(ram_off_o),
  .rom_off_o(rom_off_o), .eep_off_o(eep_off_o)
);

// File: tb/mem_decoder_bench.sv
module mem_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_B = 'hB000, ROM_S = 512, EEP_B = 'hB100, EEP_S = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] addr = '0;
  logic [3:0]  ram_pos = '0, reg_pos = '0;
  logic        rom_en = 1'b0;
  logic        sel_reg, sel_ram, sel_rom, sel_eep, miss;
  logic [6:0]  reg_off;
  logic [9:0]  ram_off;
  logic [8:0]  rom_off;
  logic [9:0]  eep_off;

  mem_decoder u_mem_decoder (
    .addr_i(addr), .ram_pos_i(ram_pos), .reg_pos_i(reg_pos), .rom_en_i(rom_en),
    .sel_reg_o(sel_reg), .sel_ram_o(sel_ram), .sel_rom_o(sel_rom), .sel_eep_o(sel_eep),
    .miss_o(miss), .reg_off_o(reg_off), .ram_off_o(ram_off),
    .rom_off_o(rom_off), .eep_off_o(eep_off)
  );

  int checks = 0, errors = 0;
  int q_res[$], q_off[$], q_addr[$], q_en[$];

  // 0 reg, 1 ram, 2 rom, 3 eep, 4 none
  function automatic void model(input int a, input int rp, input int gp, input int en,
                                output int res, output int off);
    res = 4; off = 0;
    if ((a / 4096) == gp && (a % 4096) < 96) begin res = 0; off = a % 4096; end
    else if ((a / 4096) == rp && (a % 4096) < 1024) begin res = 1; off = a % 4096; end
    else if (en != 0 && a >= ROM_B && a < ROM_B + ROM_S) begin res = 2; off = a - ROM_B; end
    else if (a >= EEP_B && a < EEP_B + EEP_S) begin res = 3; off = a - EEP_B; end
  endfunction

  function automatic string tag(input int res, input int en);
    case (res)
      0: return "R1/R3";
      1: return "R2/R3";
      2: return "R4";
      3: return (en == 0) ? "R9/R5" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input int a, input int rp, input int gp, input int en);
    int res, off;
    @(posedge clk);
    addr = 16'(a); ram_pos = 4'(rp); reg_pos = 4'(gp); rom_en = 1'(en);
    model(a, rp, gp, en, res, off);
    q_res.push_back(res); q_off.push_back(off); q_addr.push_back(a); q_en.push_back(en);
  endtask

  // compare every cycle, half a period after the drive edge
  always @(negedge clk) begin
    if (q_res.size() != 0) begin
      int res, off, a, en, exp_sel, act_sel, act_off;
      res = q_res.pop_front(); off = q_off.pop_front();
      a = q_addr.pop_front(); en = q_en.pop_front();
      exp_sel = (res < 4) ? (1 << res) : 0;
      act_sel = int'({sel_eep, sel_rom, sel_ram, sel_reg});
      checks++;
      if (act_sel != exp_sel) begin
        errors++;
        $display("FAIL %s/R6 addr=%h select act=%b exp=%b", tag(res, en), a[15:0], act_sel[3:0], exp_sel[3:0]);
      end
      checks++;
      if (int'(miss) != int'(res == 4)) begin
        errors++;
        $display("FAIL R7 addr=%h miss act=%0d exp=%0d", a[15:0], miss, res == 4);
      end
      act_off = int'(reg_off) + int'(ram_off) + int'(rom_off) + int'(eep_off);
      checks++;
      if (act_off != off || (res != 0 && reg_off != 0) || (res != 1 && ram_off != 0) ||
          (res != 2 && rom_off != 0) || (res != 3 && eep_off != 0)) begin
        errors++;
        $display("FAIL R8 addr=%h offsets act=%h/%h/%h/%h exp=%h on res %0d",
                 a[15:0], reg_off, ram_off, rom_off, eep_off, off, res);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state configuration: both windows on page 0 (R1)
    apply('h0000, 0, 0, 0);
    // R1 edges on a moved register page
    apply('h7000, 2, 7, 1); apply('h705F, 2, 7, 1); apply('h7060, 2, 7, 1); apply('h6FFF, 2, 7, 1);
    // R2 edges
    apply('h2000, 2, 7, 1); apply('h23FF, 2, 7, 1); apply('h2400, 2, 7, 1); apply('h1FFF, 2, 7, 1);
    // R3 shared page
    apply('h4000, 4, 4, 0); apply('h405F, 4, 4, 0); apply('h4060, 4, 4, 0); apply('h43FF, 4, 4, 0);
    // R4 ROM edges and priority of RAM/reg over ROM
    apply('hB000, 0, 1, 1); apply('hB0FF, 0, 1, 1); apply('hB1FF, 0, 1, 1);
    apply('hB000, 'hB, 1, 1); apply('hB010, 0, 'hB, 1);
    // R5 EEPROM edges, ROM hides its low part
    apply('hB100, 0, 1, 1); apply('hB200, 0, 1, 1); apply('hB4FF, 0, 1, 1); apply('hB500, 0, 1, 1);
    // R9 ROM gated off
    apply('hB000, 0, 1, 0); apply('hB0FF, 0, 1, 0); apply('hB100, 0, 1, 0); apply('hB1FF, 0, 1, 0);
    // R7 misses and top of map
    apply('hFFFF, 0, 1, 1); apply('h9000, 0, 1, 1);
    // random configurations, addresses biased onto the interesting pages
    for (int i = 0; i < 6000; i++) begin
      int a, rp, gp, en, pick;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      rp = seed & 15; gp = (seed >>> 4) & 15; en = (seed >>> 8) & 1;
      if (((seed >>> 9) & 3) == 0) gp = rp;
      pick = (seed >>> 11) & 3;
      a = (seed >>> 13) & 'hFFFF;
      case (pick)
        0: a = rp * 4096 + (a & 'h7FF);
        1: a = gp * 4096 + (a & 'hFF);
        2: a = 'hB000 + (a & 'h7FF);
        default: ;
      endcase
      apply(a, rp, gp, en);
    end
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule